// File: doc/BRIEF.md
# Secondary Bus Reset Sequencer

This block controls how a bridge's secondary bus leaves reset. When the primary reset is released, a timer in the primary clock domain waits through a mode-sensing interval. At the end of that interval it samples a two-bit capability input and fixes one of four bus modes. A high-speed capability makes the interval longer before the final sample is taken. A short hold in the primary domain follows. Then a toggle crosses into the secondary clock domain, where it becomes a single start pulse.

In the secondary domain, the start pulse sets up the PLL. In the PCI-X modes the PLL is taken out of reset and bypass, and its band setting is loaded. In conventional PCI the PLL stays in reset and bypass. The same pulse starts one counter. This counter releases the external secondary reset first. It then releases the internal core reset after a hold time that depends on the mode. Secondary bus transactions are refused while the core reset is active.

Every delay is a parameter, so the block can be built with the full hardware counts or with reduced counts for simulation. Asserting the primary reset at any time clears every counter and returns every output to its reset value.

Top module: `sec_bus_rst_seq`

## Requirements
- R1: While `prst_n` is low, `mode_valid_o`, `sec_rst_n_o`, `pll_rst_n_o`, `core_ready_o` and `txn_accept_o` are 0, `pll_bypass_o` is 1, and `pll_band_o` is 00.
- R2: After `prst_n` rises, the block counts `P_SENSE_SHORT` primary clocks. If `cap_i[1]` is 0 at that point, `mode_valid_o` rises and `bus_mode_o` latches {0, `cap_i[0]`}. Otherwise sensing continues to `P_SENSE_LONG` clocks, and the latched mode is {1, `cap_i[0]`}. The encoding is 00 = conventional PCI, 01 = PCI-X 66, 10 = PCI-X 100 and 11 = PCI-X 133. The latched mode does not follow later changes of `cap_i`.
- R3: `sec_rst_n_o` rises after `P_REL_PRI` primary clocks, plus three secondary clocks for the crossing, plus `P_REL_SEC` secondary clocks, all counted from the rise of `mode_valid_o`. With the two clocks in lockstep this is exactly their sum.
- R4: Once `sec_rst_n_o` is high, it stays high until the primary reset is asserted.
- R5: `core_ready_o` rises a mode-dependent number of secondary clocks after the crossing pulse arrives. The counts are `P_HOLD_CONV`, `P_HOLD_X66`, `P_HOLD_X100` and `P_HOLD_X133`. The gap after `sec_rst_n_o` rises is the hold count minus `P_REL_SEC`, which is 5 clocks in conventional mode with the default values.
- R6: In a PCI-X mode, `pll_rst_n_o` rises, `pll_bypass_o` falls and `pll_band_o` takes the mode code when the crossing pulse arrives. This is `P_REL_PRI` + 3 clocks after `mode_valid_o` in lockstep. In conventional mode, `pll_rst_n_o` stays 0, `pll_bypass_o` stays 1 and `pll_band_o` stays 00.
- R7: `txn_accept_o` is 0 while `core_ready_o` is 0, whatever the value of `txn_valid_i`. It equals `txn_valid_i` once `core_ready_o` is 1.
- R8: If `prst_n` falls at any point in the sequence, all outputs return to their R1 values by the third secondary clock edge. The next release then repeats the full sensing interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Primary clock |
| prst_n | input | 1 | Primary reset, active low, synchronous |
| sclk | input | 1 | Secondary clock |
| cap_i | input | 2 | Sensed bus capability, in the same code as the mode |
| txn_valid_i | input | 1 | A secondary bus transaction is presented |
| bus_mode_o | output | 2 | Latched bus mode |
| mode_valid_o | output | 1 | The bus mode has been decided |
| sec_rst_n_o | output | 1 | External secondary bus reset, active low |
| pll_rst_n_o | output | 1 | PLL reset, active low |
| pll_bypass_o | output | 1 | PLL bypass select |
| pll_band_o | output | 2 | PLL range and tuning select |
| core_ready_o | output | 1 | Internal secondary reset is released |
| txn_accept_o | output | 1 | Transaction is accepted |

## Verification
A primary reset can arrive on the same edge on which the secondary counter would release the external reset. Because the reset reaches the secondary domain through two flops, the release may still happen and is then withdrawn. The bench asserts `prst_n` one cycle before the release edge is due. It then checks that every output is back at its reset value by the third secondary edge. A transaction held valid across the edge where `core_ready_o` rises must be refused right up to that edge and accepted from it onward. Each mode run checks this on every cycle.

// File: rtl/sec_bus_rst_pkg.sv
// Package: shared types for the secondary bus reset sequencer.
// Assumes the mode code is also the capability code presented on cap_i.
package sec_bus_rst_pkg;

    typedef enum logic [1:0] {
        MODE_CONV = 2'b00,
        MODE_X66  = 2'b01,
        MODE_X100 = 2'b10,
        MODE_X133 = 2'b11
    } bus_mode_e;

    typedef enum logic [1:0] {
        PH_SENSE = 2'b00,
        PH_HOLD  = 2'b01,
        PH_DONE  = 2'b10
    } pri_phase_e;

endpackage

// File: rtl/sec_bus_rst_sense.sv
// Primary-domain timer. It waits the sensing interval, latches the bus mode,
// then counts a short hold and flips a launch toggle for the secondary domain.
// Assumes SENSE_LONG > SENSE_SHORT >= 1 and REL_P >= 1.
module sec_bus_rst_sense
    import sec_bus_rst_pkg::*;
#(
    parameter int SENSE_SHORT = 6675,
    parameter int SENSE_LONG  = 13347,
    parameter int REL_P       = 7
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic [1:0] cap_i,
    output bus_mode_e mode_o,
    output logic      mode_valid_o,
    output logic      launch_tgl_o
);
    localparam int CNT_MAX = (SENSE_LONG > REL_P) ? SENSE_LONG : REL_P;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SENSE_SHORT - 1);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(SENSE_LONG - 1);
    localparam logic [CNT_W-1:0] REL_LAST   = CNT_W'(REL_P - 1);

    pri_phase_e       phase;
    logic [CNT_W-1:0] cnt;

    // Sense the mode, then time the primary part of the release and launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase        <= PH_SENSE;
            cnt          <= '0;
            mode_o       <= MODE_CONV;
            mode_valid_o <= 1'b0;
            launch_tgl_o <= 1'b0;
        end else begin
            case (phase)
                PH_SENSE: begin
                    if (cnt == SHORT_LAST && !cap_i[1]) begin
                        mode_o       <= bus_mode_e'({1'b0, cap_i[0]});
                        mode_valid_o <= 1'b1;
                        phase        <= PH_HOLD;
                        cnt          <= '0;
                    end else if (cnt == LONG_LAST) begin
                        mode_o       <= bus_mode_e'({1'b1, cap_i[0]});
                        mode_valid_o <= 1'b1;
                        phase        <= PH_HOLD;
                        cnt          <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (cnt == REL_LAST) begin
                        launch_tgl_o <= ~launch_tgl_o;
                        phase        <= PH_DONE;
                        cnt          <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    phase <= PH_DONE;
                end
            endcase
        end
    end

endmodule

// File: rtl/sec_bus_rst_xpulse.sv
// Toggle-to-pulse crossing. It synchronises a level toggle into the
// destination clock and emits a one-cycle pulse per toggle.
// Assumes the toggle changes far less often than every STAGES+1 clocks.
module sec_bus_rst_xpulse #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_i,
    output logic pulse_o
);
    logic [STAGES:0] sync_q;

    // Shift the toggle through the synchroniser plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[STAGES-1:0], tgl_i};
        end
    end

    // A change between the last synchronised stage and its history is a pulse.
    always_comb begin
        pulse_o = sync_q[STAGES] ^ sync_q[STAGES-1];
    end

endmodule

// File: rtl/sec_bus_rst_hold.sv
// Secondary-domain release timer. On the start pulse it sets up the PLL for
// the mode, then releases the external reset and later the core reset.
// Assumes every hold count is larger than REL_S.
module sec_bus_rst_hold
    import sec_bus_rst_pkg::*;
#(
    parameter int REL_S     = 11,
    parameter int HOLD_CONV = 16,
    parameter int HOLD_X66  = 6687,
    parameter int HOLD_X100 = 13350,
    parameter int HOLD_X133 = 13350
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  bus_mode_e  mode_i,
    output logic       sec_rst_n_o,
    output logic       core_ready_o,
    output logic       pll_rst_n_o,
    output logic       pll_bypass_o,
    output logic [1:0] pll_band_o
);
    localparam int MAX_A   = (HOLD_CONV > HOLD_X66) ? HOLD_CONV : HOLD_X66;
    localparam int MAX_B   = (HOLD_X100 > HOLD_X133) ? HOLD_X100 : HOLD_X133;
    localparam int CNT_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] REL_LAST = CNT_W'(REL_S - 1);

    bus_mode_e        mode_q;
    logic             running;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] hold_last;

    // Select the core-reset hold for the latched mode.
    always_comb begin
        case (mode_q)
            MODE_X66:  hold_last = CNT_W'(HOLD_X66 - 1);
            MODE_X100: hold_last = CNT_W'(HOLD_X100 - 1);
            MODE_X133: hold_last = CNT_W'(HOLD_X133 - 1);
            default:   hold_last = CNT_W'(HOLD_CONV - 1);
        endcase
    end

    // Start on the pulse, set up the PLL, then count out both reset releases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q       <= MODE_CONV;
            running      <= 1'b0;
            cnt          <= '0;
            sec_rst_n_o  <= 1'b0;
            core_ready_o <= 1'b0;
            pll_rst_n_o  <= 1'b0;
            pll_bypass_o <= 1'b1;
            pll_band_o   <= 2'b00;
        end else if (start_i && !running && !core_ready_o) begin
            running <= 1'b1;
            cnt     <= '0;
            mode_q  <= mode_i;
            if (mode_i != MODE_CONV) begin
                pll_rst_n_o  <= 1'b1;
                pll_bypass_o <= 1'b0;
                pll_band_o   <= mode_i;
            end
        end else if (running) begin
            if (cnt == REL_LAST) begin
                sec_rst_n_o <= 1'b1;
            end
            if (cnt == hold_last) begin
                core_ready_o <= 1'b1;
                running      <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sec_bus_rst_seq.sv
// Top of the secondary bus reset sequencer. It joins the primary sensing
// timer, the toggle crossing and the secondary release timer, synchronises
// the primary reset into the secondary clock and gates incoming transactions.
// Assumes prst_n is already synchronous to pclk.
module sec_bus_rst_seq
    import sec_bus_rst_pkg::*;
#(
    parameter int P_SENSE_SHORT = 6675,
    parameter int P_SENSE_LONG  = 13347,
    parameter int P_REL_PRI     = 7,
    parameter int P_REL_SEC     = 11,
    parameter int P_HOLD_CONV   = 16,
    parameter int P_HOLD_X66    = 6687,
    parameter int P_HOLD_X100   = 13350,
    parameter int P_HOLD_X133   = 13350,
    parameter int P_SYNC_STAGES = 2
) (
    input  logic       pclk,
    input  logic       prst_n,
    input  logic       sclk,
    input  logic [1:0] cap_i,
    input  logic       txn_valid_i,
    output logic [1:0] bus_mode_o,
    output logic       mode_valid_o,
    output logic       sec_rst_n_o,
    output logic       pll_rst_n_o,
    output logic       pll_bypass_o,
    output logic [1:0] pll_band_o,
    output logic       core_ready_o,
    output logic       txn_accept_o
);
    bus_mode_e                mode;
    logic                     launch_tgl;
    logic                     start_pulse;
    logic [P_SYNC_STAGES-1:0] srst_pipe;
    logic                     srst_n;

    // Carry the primary reset into the secondary clock domain.
    always_ff @(posedge sclk) begin
        srst_pipe <= {srst_pipe[P_SYNC_STAGES-2:0], prst_n};
    end

    // Expose the synchronised secondary reset.
    always_comb begin
        srst_n = srst_pipe[P_SYNC_STAGES-1];
    end

    sec_bus_rst_sense #(
        .SENSE_SHORT (P_SENSE_SHORT),
        .SENSE_LONG  (P_SENSE_LONG),
        .REL_P       (P_REL_PRI)
    ) u_sense (
        .clk          (pclk),
        .rst_n        (prst_n),
        .cap_i        (cap_i),
        .mode_o       (mode),
        .mode_valid_o (mode_valid_o),
        .launch_tgl_o (launch_tgl)
    );

    sec_bus_rst_xpulse #(
        .STAGES (P_SYNC_STAGES)
    ) u_xpulse (
        .clk     (sclk),
        .rst_n   (srst_n),
        .tgl_i   (launch_tgl),
        .pulse_o (start_pulse)
    );

    sec_bus_rst_hold #(
        .REL_S     (P_REL_SEC),
        .HOLD_CONV (P_HOLD_CONV),
        .HOLD_X66  (P_HOLD_X66),
        .HOLD_X100 (P_HOLD_X100),
        .HOLD_X133 (P_HOLD_X133)
    ) u_hold (
        .clk          (sclk),
        .rst_n        (srst_n),
        .start_i      (start_pulse),
        .mode_i       (mode),
        .sec_rst_n_o  (sec_rst_n_o),
        .core_ready_o (core_ready_o),
        .pll_rst_n_o  (pll_rst_n_o),
        .pll_bypass_o (pll_bypass_o),
        .pll_band_o   (pll_band_o)
    );

    // Publish the mode and refuse transactions until the core is released.
    always_comb begin
        bus_mode_o   = mode;
        txn_accept_o = txn_valid_i & core_ready_o;
    end

endmodule

// File: rtl/sec_bus_rst_seq_chk.sv
// Checker for the secondary bus reset sequencer, bound to the top module.
// Assumes that the hold counts exceed the secondary release count.
module sec_bus_rst_seq_chk (
    input logic       pclk,
    input logic       sclk,
    input logic       prst_n,
    input logic       srst_n,
    input logic [1:0] bus_mode_o,
    input logic       mode_valid_o,
    input logic       sec_rst_n_o,
    input logic       pll_rst_n_o,
    input logic       pll_bypass_o,
    input logic       core_ready_o,
    input logic       txn_accept_o
);
    AST_MODE_HELD: assert property (@(posedge pclk) disable iff (!prst_n)
        (mode_valid_o && $past(mode_valid_o)) |-> $stable(bus_mode_o)); // R2

    AST_EXT_AFTER_MODE: assert property (@(posedge sclk) disable iff (!prst_n || !srst_n)
        sec_rst_n_o |-> mode_valid_o); // R3

    AST_EXT_STAYS: assert property (@(posedge sclk) disable iff (!prst_n || !srst_n)
        sec_rst_n_o |=> sec_rst_n_o); // R4

    AST_CORE_AFTER_EXT: assert property (@(posedge sclk) disable iff (!prst_n || !srst_n)
        $rose(core_ready_o) |-> $past(sec_rst_n_o)); // R5

    AST_PLL_OUT_OF_BYPASS: assert property (@(posedge sclk) disable iff (!prst_n || !srst_n)
        pll_rst_n_o |-> !pll_bypass_o); // R6

    AST_CONV_KEEPS_PLL: assert property (@(posedge sclk) disable iff (!prst_n || !srst_n)
        (mode_valid_o && bus_mode_o == 2'b00) |-> (!pll_rst_n_o && pll_bypass_o)); // R6

    AST_NO_EARLY_ACCEPT: assert property (@(posedge sclk) disable iff (!prst_n || !srst_n)
        txn_accept_o |-> sec_rst_n_o); // R7

endmodule

bind sec_bus_rst_seq sec_bus_rst_seq_chk u_chk (
    .pclk         (pclk),
    .sclk         (sclk),
    .prst_n       (prst_n),
    .srst_n       (srst_n),
    .bus_mode_o   (bus_mode_o),
    .mode_valid_o (mode_valid_o),
    .sec_rst_n_o  (sec_rst_n_o),
    .pll_rst_n_o  (pll_rst_n_o),
    .pll_bypass_o (pll_bypass_o),
    .core_ready_o (core_ready_o),
    .txn_accept_o (txn_accept_o)
);

// File: tb/sec_bus_rst_seq_tb.sv
// Directed bench: one task per scenario, the two clocks in lockstep.
module sec_bus_rst_seq_tb;
    localparam int SHORT = 40;
    localparam int LONG  = 90;
    localparam int RELP  = 7;
    localparam int RELS  = 11;
    localparam int XLAT  = 3;
    localparam int HCONV = 16;
    localparam int H66   = 50;
    localparam int H100  = 70;
    localparam int H133  = 80;

    logic       clk = 1'b0;
    logic       prst_n = 1'b0;
    logic [1:0] cap_i = 2'b00;
    logic       txn_valid_i = 1'b1;
    logic [1:0] bus_mode_o;
    logic       mode_valid_o, sec_rst_n_o, pll_rst_n_o, pll_bypass_o;
    logic [1:0] pll_band_o;
    logic       core_ready_o, txn_accept_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sec_bus_rst_seq #(
        .P_SENSE_SHORT (SHORT), .P_SENSE_LONG (LONG),
        .P_REL_PRI (RELP), .P_REL_SEC (RELS),
        .P_HOLD_CONV (HCONV), .P_HOLD_X66 (H66),
        .P_HOLD_X100 (H100), .P_HOLD_X133 (H133)
    ) u_dut (
        .pclk (clk), .prst_n (prst_n), .sclk (clk), .cap_i (cap_i),
        .txn_valid_i (txn_valid_i), .bus_mode_o (bus_mode_o),
        .mode_valid_o (mode_valid_o), .sec_rst_n_o (sec_rst_n_o),
        .pll_rst_n_o (pll_rst_n_o), .pll_bypass_o (pll_bypass_o),
        .pll_band_o (pll_band_o), .core_ready_o (core_ready_o),
        .txn_accept_o (txn_accept_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check_reset_values(input string req);
        chk(req, "mode_valid", int'(mode_valid_o), 0);
        chk(req, "sec_rst_n", int'(sec_rst_n_o), 0);
        chk(req, "pll_rst_n", int'(pll_rst_n_o), 0);
        chk(req, "pll_bypass", int'(pll_bypass_o), 1);
        chk(req, "pll_band", int'(pll_band_o), 0);
        chk(req, "core_ready", int'(core_ready_o), 0);
        chk(req, "txn_accept", int'(txn_accept_o), 0);
    endtask

    // R1: hold reset and check every output.
    task automatic t_reset_state();
        @(negedge clk);
        prst_n = 1'b0;
        repeat (6) tick();
        check_reset_values("R1");
    endtask

    // R2, R3, R5, R6, R7: one full release in a given capability setting.
    task automatic t_mode(input logic [1:0] cap, input int hold);
        int n = 0;
        int k = 0;
        int kp = -1;
        int ks = -1;
        int kc = -1;
        int bad_accept = 0;
        int exp_sense;
        bit is_x;
        exp_sense = cap[1] ? LONG : SHORT;
        is_x = (cap != 2'b00);
        @(negedge clk);
        prst_n = 1'b0;
        cap_i  = cap;
        repeat (4) tick();
        @(negedge clk);
        prst_n = 1'b1;
        while (n < LONG + 10) begin
            tick();
            n++;
            if (mode_valid_o) break;
        end
        chk("R2", "sense length", n, exp_sense);
        chk("R2", "mode code", int'(bus_mode_o), int'(cap));
        cap_i = ~cap;
        while (k < 300) begin
            if (!core_ready_o && txn_accept_o) bad_accept++;
            tick();
            k++;
            if (pll_rst_n_o && kp < 0) kp = k;
            if (sec_rst_n_o && ks < 0) ks = k;
            if (core_ready_o && kc < 0) begin
                kc = k;
                break;
            end
        end
        chk("R3", "ext release delay", ks, RELP + XLAT + RELS);
        chk("R5", "core release delay", kc - ks, hold - RELS);
        chk("R6", "pll release cycle", kp, is_x ? RELP + XLAT : -1);
        chk("R6", "pll bypass", int'(pll_bypass_o), is_x ? 0 : 1);
        chk("R6", "pll band", int'(pll_band_o), is_x ? int'(cap) : 0);
        chk("R7", "accept before ready", bad_accept, 0);
        chk("R7", "accept after ready", int'(txn_accept_o), 1);
        chk("R2", "mode kept after cap change", int'(bus_mode_o), int'(cap));
        repeat (5) tick();
        chk("R4", "ext reset stays released", int'(sec_rst_n_o), 1);
        cap_i = cap;
    endtask

    // R8: reset one cycle before the external release is due.
    task automatic t_reset_collide();
        int k = 0;
        @(negedge clk);
        prst_n = 1'b0;
        cap_i  = 2'b11;
        repeat (4) tick();
        @(negedge clk);
        prst_n = 1'b1;
        while (!mode_valid_o && k < LONG + 10) begin
            tick();
            k++;
        end
        repeat (RELP + XLAT + RELS - 1) tick();
        chk("R8", "pll released before collision", int'(pll_rst_n_o), 1);
        @(negedge clk);
        prst_n = 1'b0;
        repeat (3) tick();
        check_reset_values("R8");
    endtask

    // R8: reset during sensing restarts the full interval.
    task automatic t_reset_in_sense();
        int n = 0;
        @(negedge clk);
        prst_n = 1'b0;
        cap_i  = 2'b01;
        repeat (4) tick();
        @(negedge clk);
        prst_n = 1'b1;
        repeat (SHORT - 3) tick();
        @(negedge clk);
        prst_n = 1'b0;
        repeat (3) tick();
        chk("R8", "mode_valid cleared", int'(mode_valid_o), 0);
        @(negedge clk);
        prst_n = 1'b1;
        while (n < LONG + 10) begin
            tick();
            n++;
            if (mode_valid_o) break;
        end
        chk("R8", "full sense after re-reset", n, SHORT);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_mode(2'b00, HCONV);
        t_mode(2'b01, H66);
        t_mode(2'b10, H100);
        t_mode(2'b11, H133);
        t_reset_collide();
        t_reset_in_sense();
        t_mode(2'b00, HCONV);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule